// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits next to a small 8-bit processor core and, whenever the core reports that the current instruction has finished, decides whether exception processing begins and which vector the core must fetch. It takes the reset causes, a software-interrupt request decoded from the finishing instruction, the external interrupt lines, the status flags and enable bits of the timer, serial and SPI peripherals, and the global interrupt mask bit. It then emits a one-cycle take pulse, a 16-bit vector address and a one-hot source identifier.

The sources are ranked by fixed priority. Each peripheral source is a group of flag/enable pairs that are ORed together into one request. Reset cannot be masked. The software interrupt ignores the global mask because it belongs to the instruction itself. The flags are level inputs and this block never clears them, so a request raised in the middle of an instruction stays visible until the next boundary as long as its flag stays set. In the same cycle as the take pulse, the block tells the core to set the global mask bit.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `take` is high only in the cycle that follows a clock edge at which `instr_done` was high. After `rst`, `take`, `set_imask`, `vector` and `src_id` are all zero.
- R2: Any of `por_req`, `pin_rst_req` or `wdog_req` at a boundary selects source bit 0 with vector 0x3FFE. This happens whatever the value of `i_mask` and ahead of every other source.
- R3: `swi_req` at a boundary selects source bit 1 with vector 0x3FFC even when `i_mask` is 1. It outranks every hardware interrupt.
- R4: `irq_line` or `portb_line` at a boundary with `i_mask` at 0 selects source bit 2 with vector 0x3FFA. With `i_mask` at 1 these lines are ignored.
- R5: The timer group requests when any pair is set in `tmr_flags & tmr_en`. Bit 0 is capture, bit 1 is compare and bit 2 is overflow. The group selects source bit 3 with vector 0x3FF8, and only when `i_mask` is 0.
- R6: The serial group requests on any of these pairs: `sci_flags[0]` (transmit empty) with `sci_en[0]`; `sci_flags[1]` (transmit complete) with `sci_en[1]`; `sci_flags[2]` (receive full) or `sci_flags[3]` (overrun) with `sci_en[2]`; `sci_flags[4]` (idle) with `sci_en[3]`. It selects source bit 4 with vector 0x3FF6, and only when `i_mask` is 0.
- R7: The SPI group requests when `spi_flags[0]` (transfer done) or `spi_flags[1]` (mode fault) is set and `spi_en` is 1. It selects source bit 5 with vector 0x3FF4, and only when `i_mask` is 0.
- R8: When several hardware sources request at once, the winner follows the order external, then timer, then serial, then SPI.
- R9: A flag whose matching enable is 0 causes no take.
- R10: `take` lasts one cycle unless the next cycle is also a boundary with a request. `set_imask` is high in exactly the cycles where `take` is high. `vector` and `src_id` hold their values in every cycle without a take.
- R11: `vector` is always even, so it is the address of the high byte of its pair.
- R12: A request raised between boundaries causes no take until the next boundary. At that boundary it is taken if its level is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of this block |
| por_req | input | 1 | Power-on reset cause |
| pin_rst_req | input | 1 | External reset pin cause |
| wdog_req | input | 1 | Watchdog reset cause |
| swi_req | input | 1 | Finishing instruction is a software interrupt |
| irq_line | input | 1 | External interrupt pin request |
| portb_line | input | 1 | Port B pin interrupt request |
| i_mask | input | 1 | Global interrupt mask bit |
| instr_done | input | 1 | Current instruction completes this cycle |
| tmr_flags | input | 3 | Timer flags: capture, compare, overflow |
| tmr_en | input | 3 | Timer enables matching `tmr_flags` |
| sci_flags | input | 5 | Serial flags: tx empty, tx complete, rx full, overrun, idle |
| sci_en | input | 4 | Serial enables: tx empty, tx complete, receive, idle |
| spi_flags | input | 2 | SPI flags: transfer done, mode fault |
| spi_en | input | 1 | SPI interrupt enable |
| take | output | 1 | Start exception processing |
| vector | output | 16 | Vector address of the chosen source |
| src_id | output | 6 | One-hot chosen source |
| set_imask | output | 1 | Core must set the global mask bit |

## Verification
The clocked properties assume the inputs are settled before each rising edge. They also assume `instr_done` is a plain level that the core controls, with no relation to the flags that the block relies on. The hold property additionally assumes that reset has been applied for at least one edge. The bench changes every input only on the falling clock edge, holds reset for several cycles at the start, and raises `instr_done` for single cycles or short back-to-back runs. Every flag combination it applies is a legal level pattern, and none relies on the block clearing anything.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NSRC    = 6;
    localparam int ADDR_W  = 16;
    localparam logic [ADDR_W-1:0] VEC_TOP = 16'h3FFE;
    localparam int TMR_N   = 3;
    localparam int SCI_NF  = 5;
    localparam int SCI_NE  = 4;
    localparam int SPI_NF  = 2;
    localparam int IDX_W   = $clog2(NSRC);

    // Priority order: lower index wins
    typedef enum logic [IDX_W-1:0] {
        SRC_RESET = 3'd0,
        SRC_SWI   = 3'd1,
        SRC_EXT   = 3'd2,
        SRC_TMR   = 3'd3,
        SRC_SCI   = 3'd4,
        SRC_SPI   = 3'd5
    } src_e;

    typedef struct packed {
        logic [TMR_N-1:0]  flag;
        logic [TMR_N-1:0]  en;
    } tmr_in_t;

    typedef struct packed {
        logic [SCI_NF-1:0] flag;
        logic [SCI_NE-1:0] en;
    } sci_in_t;

    typedef struct packed {
        logic [SPI_NF-1:0] flag;
        logic              en;
    } spi_in_t;

    typedef struct packed {
        logic                  take;
        logic [ADDR_W-1:0]     vec;
        logic [NSRC-1:0]       id;
    } sel_t;

    // Vector pairs descend two bytes per priority slot
    function automatic logic [ADDR_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [ADDR_W-1:0] off;
        off = ADDR_W'(idx) << 1;
        return VEC_TOP - off;
    endfunction

    function automatic logic [IDX_W-1:0] idx_of(input logic [NSRC-1:0] oh);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (oh[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqv_group.sv
module irqv_group #(
    parameter int NPAIRS = 2
) (
    input  logic [NPAIRS-1:0] flag,
    input  logic [NPAIRS-1:0] en,
    output logic              req
);
    logic [NPAIRS-1:0] hit;

    for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
        assign hit[g] = flag[g] & en[g];
    end

    assign req = |hit;
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] above;

    assign above[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign above[g+1] = above[g] | req[g];
        assign grant[g]   = req[g] & ~above[g];
    end

    assign any = above[N];

    always_comb begin
        assert_grant_subset_R8: assert ((grant & ~req) == '0);
        assert_grant_single_R8: assert ($countones(grant) == (any ? 1 : 0));
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        por_req,
    input  logic        pin_rst_req,
    input  logic        wdog_req,
    input  logic        swi_req,
    input  logic        irq_line,
    input  logic        portb_line,
    input  logic        i_mask,
    input  logic        instr_done,
    input  logic [2:0]  tmr_flags,
    input  logic [2:0]  tmr_en,
    input  logic [4:0]  sci_flags,
    input  logic [3:0]  sci_en,
    input  logic [1:0]  spi_flags,
    input  logic        spi_en,
    output logic        take,
    output logic [15:0] vector,
    output logic [5:0]  src_id,
    output logic        set_imask
);
    tmr_in_t tmr;
    sci_in_t sci;
    spi_in_t spi;

    assign tmr = '{flag: tmr_flags, en: tmr_en};
    assign sci = '{flag: sci_flags, en: sci_en};
    assign spi = '{flag: spi_flags, en: spi_en};

    logic tmr_req, sci_req, spi_req;

    irqv_group #(.NPAIRS(TMR_N)) u_tmr (
        .flag (tmr.flag),
        .en   (tmr.en),
        .req  (tmr_req)
    );

    // Receive-full and overrun share the receive enable
    irqv_group #(.NPAIRS(SCI_NE)) u_sci (
        .flag ({sci.flag[4], sci.flag[3] | sci.flag[2], sci.flag[1], sci.flag[0]}),
        .en   (sci.en),
        .req  (sci_req)
    );

    irqv_group #(.NPAIRS(SPI_NF)) u_spi (
        .flag (spi.flag),
        .en   ({SPI_NF{spi.en}}),
        .req  (spi_req)
    );

    logic            rst_any;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;
    logic            any_req;

    assign rst_any = por_req | pin_rst_req | wdog_req;

    always_comb begin
        req          = '0;
        req[SRC_RESET] = rst_any;
        req[SRC_SWI]   = swi_req;
        req[SRC_EXT]   = (irq_line | portb_line) & ~i_mask;
        req[SRC_TMR]   = tmr_req & ~i_mask;
        req[SRC_SCI]   = sci_req & ~i_mask;
        req[SRC_SPI]   = spi_req & ~i_mask;
    end

    irqv_arbiter #(.N(NSRC)) u_arb (
        .req   (req),
        .grant (grant),
        .any   (any_req)
    );

    sel_t nxt, cur;

    always_comb begin
        nxt = cur;
        nxt.take = 1'b0;
        if (instr_done && any_req) begin
            nxt.take = 1'b1;
            nxt.vec  = vec_of(idx_of(grant));
            nxt.id   = grant;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            set_imask <= 1'b0;
        end else begin
            cur       <= nxt;
            set_imask <= instr_done & any_req;
        end
    end

    assign take   = cur.take;
    assign vector = cur.vec;
    assign src_id = cur.id;

    assert_take_boundary_R1: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(instr_done));

    assert_reset_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (instr_done && (por_req || pin_rst_req || wdog_req)) |=>
            (take && src_id == 6'b000001 && vector == 16'h3FFE));

    assert_swi_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
        (instr_done && swi_req && !(por_req || pin_rst_req || wdog_req)) |=>
            (take && src_id == 6'b000010));

    assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (instr_done && i_mask && !swi_req && !(por_req || pin_rst_req || wdog_req)) |=> !take);

    assert_imask_with_take_R10: assert property (@(posedge clk) disable iff (rst)
        set_imask == take);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!take && $past(!rst)) |-> ($stable(vector) && $stable(src_id)));

    assert_even_R11: assert property (@(posedge clk) disable iff (rst)
        take |-> (vector[0] == 1'b0 && $countones(src_id) == 1));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        por_req, pin_rst_req, wdog_req, swi_req;
    logic        irq_line, portb_line, i_mask, instr_done;
    logic [2:0]  tmr_flags, tmr_en;
    logic [4:0]  sci_flags;
    logic [3:0]  sci_en;
    logic [1:0]  spi_flags;
    logic        spi_en;
    logic        take, set_imask;
    logic [15:0] vector;
    logic [5:0]  src_id;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk, .rst, .por_req, .pin_rst_req, .wdog_req, .swi_req,
        .irq_line, .portb_line, .i_mask, .instr_done,
        .tmr_flags, .tmr_en, .sci_flags, .sci_en, .spi_flags, .spi_en,
        .take, .vector, .src_id, .set_imask
    );

    // {rst3, swi, irq, pb, im, tf3, te3, sf5, se4, pf2, pe, exp_src6}
    localparam int NV = 21;
    localparam logic [30:0] TBL [NV] = '{
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b00000,4'b0000,2'b00,1'b0,6'b000000}, // idle
        {3'b001,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b00000,4'b0000,2'b00,1'b0,6'b000001}, // R2 por
        {3'b100,1'b1,1'b1,1'b1,1'b1,3'b111,3'b111,5'b11111,4'b1111,2'b11,1'b1,6'b000001}, // R2 wdog masked
        {3'b000,1'b1,1'b0,1'b0,1'b1,3'b000,3'b000,5'b00000,4'b0000,2'b00,1'b0,6'b000010}, // R3 swi masked
        {3'b000,1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,5'b00000,4'b0000,2'b00,1'b0,6'b000100}, // R4 irq
        {3'b000,1'b0,1'b0,1'b1,1'b0,3'b000,3'b000,5'b00000,4'b0000,2'b00,1'b0,6'b000100}, // R4 portb
        {3'b000,1'b0,1'b0,1'b1,1'b1,3'b000,3'b000,5'b00000,4'b0000,2'b00,1'b0,6'b000000}, // R4 masked
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b001,3'b001,5'b00000,4'b0000,2'b00,1'b0,6'b001000}, // R5 capture
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b100,3'b100,5'b00000,4'b0000,2'b00,1'b0,6'b001000}, // R5 overflow
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b100,3'b011,5'b00000,4'b0000,2'b00,1'b0,6'b000000}, // R9 timer
        {3'b000,1'b0,1'b0,1'b0,1'b1,3'b010,3'b010,5'b00000,4'b0000,2'b00,1'b0,6'b000000}, // R5 masked
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b00001,4'b0001,2'b00,1'b0,6'b010000}, // R6 tx empty
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b01000,4'b0100,2'b00,1'b0,6'b010000}, // R6 overrun
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b10000,4'b1000,2'b00,1'b0,6'b010000}, // R6 idle
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b10001,4'b0110,2'b00,1'b0,6'b000000}, // R9 sci
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b00000,4'b0000,2'b10,1'b1,6'b100000}, // R7 mode fault
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b00000,4'b0000,2'b11,1'b0,6'b000000}, // R9 spi
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b001,3'b001,5'b00010,4'b0010,2'b01,1'b1,6'b001000}, // R8 tmr>sci>spi
        {3'b000,1'b0,1'b0,1'b0,1'b0,3'b000,3'b000,5'b00100,4'b0100,2'b01,1'b1,6'b010000}, // R8 sci>spi
        {3'b000,1'b0,1'b0,1'b1,1'b0,3'b010,3'b010,5'b00000,4'b0000,2'b00,1'b0,6'b000100}, // R8 ext>tmr
        {3'b010,1'b1,1'b1,1'b0,1'b0,3'b000,3'b000,5'b00000,4'b0000,2'b00,1'b0,6'b000001}  // R2 over swi
    };

    function automatic logic [15:0] exp_vec(input logic [5:0] s);
        logic [15:0] v;
        v = 16'h0000;
        for (int i = 0; i < 6; i++) begin
            if (s[i]) v = 16'h3FFE - 16'(2 * i);
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        {por_req, pin_rst_req, wdog_req, swi_req} = '0;
        {irq_line, portb_line, i_mask, instr_done} = '0;
        tmr_flags = '0; tmr_en = '0; sci_flags = '0; sci_en = '0;
        spi_flags = '0; spi_en = 1'b0;
    endtask

    task automatic apply(input logic [30:0] e);
        {pin_rst_req, wdog_req, por_req} = {e[29], e[30], e[28]};
        swi_req = e[27]; irq_line = e[26]; portb_line = e[25]; i_mask = e[24];
        tmr_flags = e[23:21]; tmr_en = e[20:18];
        sci_flags = e[17:13]; sci_en = e[12:9];
        spi_flags = e[8:7]; spi_en = e[6];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] held_v;
        logic [5:0]  held_s;
        clear_inputs();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset take", 32'(take), 0);
        chk("R1 reset vector", 32'(vector), 0);
        chk("R1 reset src", 32'(src_id), 0);
        chk("R1 reset imask", 32'(set_imask), 0);

        for (int k = 0; k < NV; k++) begin
            logic [5:0] es;
            es = TBL[k][5:0];
            apply(TBL[k]);
            instr_done = 1'b1;
            @(negedge clk);
            instr_done = 1'b0;
            chk($sformatf("R2-7 row%0d take", k), 32'(take), 32'(es != 0));
            chk($sformatf("R10 row%0d imask", k), 32'(set_imask), 32'(es != 0));
            if (es != 0) begin
                chk($sformatf("R8 row%0d src", k), 32'(src_id), 32'(es));
                chk($sformatf("R11 row%0d vector", k), 32'(vector), 32'(exp_vec(es)));
            end
            @(negedge clk);
            chk($sformatf("R10 row%0d pulse", k), 32'(take), 0);
            clear_inputs();
        end

        // R12 / R1: request between boundaries waits
        clear_inputs();
        tmr_flags = 3'b010; tmr_en = 3'b010;
        repeat (3) @(negedge clk);
        chk("R12 no boundary", 32'(take), 0);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        chk("R12 taken at boundary", 32'(src_id), 32'(6'b001000));
        chk("R12 take", 32'(take), 1);

        // R10 hold while inputs change without a boundary
        held_v = vector; held_s = src_id;
        clear_inputs();
        spi_flags = 2'b01; spi_en = 1'b1; irq_line = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 hold vector", 32'(vector), 32'(held_v));
        chk("R10 hold src", 32'(src_id), 32'(held_s));

        // R10 back-to-back boundaries, source drops between
        instr_done = 1'b1;
        @(negedge clk);
        chk("R8 b2b first", 32'(src_id), 32'(6'b000100));
        irq_line = 1'b0;
        @(negedge clk);
        instr_done = 1'b0;
        chk("R10 b2b take", 32'(take), 1);
        chk("R7 b2b second", 32'(src_id), 32'(6'b100000));
        chk("R7 b2b vector", 32'(vector), 32'h3FF4);
        @(negedge clk);
        chk("R10 b2b end", 32'(take), 0);

        // R1 reset clears held outputs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 rst clears src", 32'(src_id), 0);
        chk("R1 rst clears vector", 32'(vector), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule